// File: doc/BRIEF.md
# Unaligned Load-Store Access Splitter

This block connects a processor-side request port to a memory that moves only whole 8-byte units. The memory is addressed by unit index, which is the byte address with its three low bits removed. A request names a byte address, a size of 1, 2, 4 or 8 bytes, a read or write direction and 64 bits of write data. The block turns each request into the fewest whole-unit memory transactions that cover the addressed bytes.

A load that stays inside one unit costs one read. A load that crosses into the next unit costs two reads, and the two returned words are joined and shifted down so that the result arrives right-aligned and zero-extended. The memory cannot write single bytes, so a store always reads the covered unit or units, lays the new bytes over the old ones and writes whole units back. Each completed access reports whether it was naturally aligned, misaligned inside one unit, or split across two. In strict mode a misaligned request is refused with a fault and touches no memory.

Only one access is in progress at a time, and the memory side has at most one transaction outstanding.

Top module: `unaligned_splitter`

## Requirements
- R1: The first memory transaction of an access uses unit index `addr >> 3`. A second unit is addressed as that index plus one, wrapping at the top of the address space.
- R2: Size code `req_size` selects 1, 2, 4 or 8 bytes for codes 0, 1, 2 and 3. A load whose bytes lie in one unit performs exactly one read. Its result holds the byte at `addr` in bits 7:0 and the following bytes above it, and every bit above the access size is zero.
- R3: A load that crosses a unit boundary performs exactly two reads, unit N and then unit N+1. Its result is the addressed bytes in address order, right-aligned and zero-extended.
- R4: A store that stays inside one unit performs one read and then one write of the same unit. Only the addressed bytes change, and they take the low bytes of `req_wdata`. Write-data bytes above the access size have no effect.
- R5: A store that crosses a unit boundary performs, in this order: read N, read N+1, write N, write N+1. The start of the new data lands in the upper bytes of unit N, the rest lands in the lower bytes of unit N+1, and no other byte changes.
- R6: With `rsp_done`, `rsp_class` reports 0 when `addr` is a multiple of the size, 2 when the bytes cross a unit boundary, and 1 otherwise. A store returns zero `rsp_rdata`.
- R7: With `strict_en` high, a request whose address is not a multiple of its size completes with `rsp_done` and `rsp_fault` high one cycle after acceptance. It returns zero data and issues no memory transaction. Aligned requests proceed normally, and `rsp_fault` is low on every completion that is not refused.
- R8: `req_ready` is low from the cycle after a request is accepted until its `rsp_done`. After a read is accepted, no new memory request is made until its data has returned. A memory request that is not yet accepted keeps its unit and direction.
- R9: After reset `req_ready` is high, and `rsp_done` and `mem_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strict_en | input | 1 | Refuse misaligned requests with a fault |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_we | input | 1 | 1 for a store, 0 for a load |
| req_wdata | input | 64 | Store data, right-aligned |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 1 | Request refused in strict mode |
| rsp_class | output | 2 | 0 aligned, 1 misaligned in one unit, 2 split |
| rsp_rdata | output | 64 | Load data, right-aligned, zero-extended |
| mem_valid | output | 1 | Memory transaction request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_unit | output | ADDR_W-3 | Unit index |
| mem_we | output | 1 | Whole-unit write |
| mem_wdata | output | 64 | Unit write data |
| mem_rvalid | input | 1 | Read data present |
| mem_rdata | input | 64 | Unit read data |

## Verification
The bench sweeps every byte address of a 64-byte memory with all four sizes, as both loads and stores. It does this once with strict mode off and once with it on. Every offset inside a unit is therefore paired with every size, which separates aligned, in-unit misaligned and split cases, and includes the split that wraps from the last unit to unit 0. For each access the logged memory transactions are compared with the expected read/write order, and the whole memory image is compared with a byte-level model. This exposes splice or merge errors that corrupt neighbouring bytes. The memory's ready signal stalls on a pseudo-random pattern to exercise requests that are held while waiting.

// File: rtl/us_pkg.sv
package us_pkg;
  typedef enum logic [1:0] {
    CLS_ALIGNED = 2'd0,
    CLS_INUNIT  = 2'd1,
    CLS_SPLIT   = 2'd2
  } acc_class_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_LO, ST_WT_LO, ST_RD_HI, ST_WT_HI, ST_WR_LO, ST_WR_HI, ST_FIN
  } seq_state_e;
endpackage

// File: rtl/us_classify.sv
module us_classify
  import us_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int UNIT_BYTES = 8,
  localparam int OFF_W     = $clog2(UNIT_BYTES),
  localparam int UNIT_W    = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [UNIT_W-1:0] unit_idx,
  output logic [OFF_W-1:0]  offset,
  output logic [OFF_W:0]    byte_cnt,
  output logic              misaligned,
  output logic              split,
  output acc_class_e        cls
);
  logic [OFF_W-1:0] low_mask;
  logic [OFF_W+1:0] end_pos;

  always_comb begin
    unit_idx   = addr[ADDR_W-1:OFF_W];
    offset     = addr[OFF_W-1:0];
    byte_cnt   = (OFF_W+1)'(1) << size;
    low_mask   = OFF_W'(byte_cnt - 1'b1);
    misaligned = (offset & low_mask) != '0;
    end_pos    = {1'b0, offset} + {1'b0, byte_cnt};
    split      = end_pos > (OFF_W+2)'(UNIT_BYTES);
    if (!misaligned)  cls = CLS_ALIGNED;
    else if (split)   cls = CLS_SPLIT;
    else              cls = CLS_INUNIT;
  end
endmodule

// File: rtl/us_lane_merge.sv
module us_lane_merge #(
  parameter int UNIT_BYTES = 8,
  localparam int OFF_W     = $clog2(UNIT_BYTES),
  localparam int DW        = 8 * UNIT_BYTES
) (
  input  logic [DW-1:0]    stage_lo,
  input  logic [DW-1:0]    stage_hi,
  input  logic [OFF_W-1:0] offset,
  input  logic [OFF_W:0]   byte_cnt,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    load_data,
  output logic [DW-1:0]    merged_lo,
  output logic [DW-1:0]    merged_hi
);
  logic [2*DW-1:0] pair;
  logic [2*DW-1:0] pair_down;
  logic [2*DW-1:0] new_up;
  logic [2*DW-1:0] merged;
  logic [OFF_W+2:0] sh_bits;

  always_comb begin
    sh_bits   = {offset, 3'b000};
    pair      = {stage_hi, stage_lo};
    pair_down = pair >> sh_bits;
    new_up    = {{DW{1'b0}}, wdata} << sh_bits;
  end

  for (genvar b = 0; b < UNIT_BYTES; b++) begin : g_load
    assign load_data[b*8 +: 8] = (b < int'(byte_cnt)) ? pair_down[b*8 +: 8] : 8'h00;
  end

  for (genvar i = 0; i < 2*UNIT_BYTES; i++) begin : g_merge
    logic in_win;
    assign in_win = (i >= int'(offset)) && (i < int'(offset) + int'(byte_cnt));
    assign merged[i*8 +: 8] = in_win ? new_up[i*8 +: 8] : pair[i*8 +: 8];
  end

  assign merged_lo = merged[DW-1:0];
  assign merged_hi = merged[2*DW-1:DW];
endmodule

// File: rtl/unaligned_splitter.sv
module unaligned_splitter
  import us_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int UNIT_BYTES = 8,
  localparam int OFF_W     = $clog2(UNIT_BYTES),
  localparam int UNIT_W    = ADDR_W - OFF_W,
  localparam int DW        = 8 * UNIT_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strict_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_we,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_done,
  output logic              rsp_fault,
  output logic [1:0]        rsp_class,
  output logic [DW-1:0]     rsp_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [UNIT_W-1:0] mem_unit,
  output logic              mem_we,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DW-1:0]     mem_rdata
);
  seq_state_e        state;
  logic [UNIT_W-1:0] r_unit;
  logic [OFF_W-1:0]  r_off;
  logic [OFF_W:0]    r_cnt;
  logic              r_we, r_split;
  acc_class_e        r_cls;
  logic [DW-1:0]     r_wdata, stage_lo, stage_hi;

  logic [UNIT_W-1:0] c_unit;
  logic [OFF_W-1:0]  c_off;
  logic [OFF_W:0]    c_cnt;
  logic              c_mis, c_split;
  acc_class_e        c_cls;
  logic [DW-1:0]     load_data, merged_lo, merged_hi;

  us_classify #(.ADDR_W(ADDR_W), .UNIT_BYTES(UNIT_BYTES)) u_classify (
    .addr(req_addr), .size(req_size), .unit_idx(c_unit), .offset(c_off),
    .byte_cnt(c_cnt), .misaligned(c_mis), .split(c_split), .cls(c_cls)
  );

  us_lane_merge #(.UNIT_BYTES(UNIT_BYTES)) u_merge (
    .stage_lo(stage_lo), .stage_hi(stage_hi), .offset(r_off), .byte_cnt(r_cnt),
    .wdata(r_wdata), .load_data(load_data), .merged_lo(merged_lo), .merged_hi(merged_hi)
  );

  logic hi_phase;
  always_comb begin
    hi_phase  = (state == ST_RD_HI) || (state == ST_WR_HI);
    req_ready = (state == ST_IDLE);
    mem_valid = (state == ST_RD_LO) || (state == ST_RD_HI) ||
                (state == ST_WR_LO) || (state == ST_WR_HI);
    mem_we    = (state == ST_WR_LO) || (state == ST_WR_HI);
    mem_unit  = hi_phase ? r_unit + 1'b1 : r_unit;
    mem_wdata = (state == ST_WR_HI) ? merged_hi : merged_lo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      r_unit    <= '0;
      r_off     <= '0;
      r_cnt     <= '0;
      r_we      <= 1'b0;
      r_split   <= 1'b0;
      r_cls     <= CLS_ALIGNED;
      r_wdata   <= '0;
      stage_lo  <= '0;
      stage_hi  <= '0;
      rsp_done  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_class <= 2'd0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          r_unit   <= c_unit;
          r_off    <= c_off;
          r_cnt    <= c_cnt;
          r_we     <= req_we;
          r_split  <= c_split;
          r_cls    <= c_cls;
          r_wdata  <= req_wdata;
          stage_hi <= '0;
          if (strict_en && c_mis) begin
            rsp_done  <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_class <= c_cls;
            rsp_rdata <= '0;
          end else begin
            state <= ST_RD_LO;
          end
        end
        ST_RD_LO: if (mem_ready) state <= ST_WT_LO;
        ST_WT_LO: if (mem_rvalid) begin
          stage_lo <= mem_rdata;
          if (r_split)   state <= ST_RD_HI;
          else if (r_we) state <= ST_WR_LO;
          else           state <= ST_FIN;
        end
        ST_RD_HI: if (mem_ready) state <= ST_WT_HI;
        ST_WT_HI: if (mem_rvalid) begin
          stage_hi <= mem_rdata;
          state    <= r_we ? ST_WR_LO : ST_FIN;
        end
        ST_WR_LO: if (mem_ready) state <= r_split ? ST_WR_HI : ST_FIN;
        ST_WR_HI: if (mem_ready) state <= ST_FIN;
        ST_FIN: begin
          rsp_done  <= 1'b1;
          rsp_fault <= 1'b0;
          rsp_class <= r_cls;
          rsp_rdata <= r_we ? '0 : load_data;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_unit) && $stable(mem_we)); // R8
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    mem_valid && mem_ready && !mem_we |=> !mem_valid); // R8
  AST_FAULT_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    rsp_done && rsp_fault |-> !mem_valid); // R7
  AST_FAULT_MISALIGNED: assert property (@(posedge clk) disable iff (rst)
    rsp_done && rsp_fault |-> rsp_class != 2'd0); // R7
  AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> rsp_class != 2'd3); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !req_ready); // R8
endmodule

// File: tb/unaligned_splitter_bench.sv
module unaligned_splitter_bench;
  localparam int AW = 6;
  localparam int UW = 3;
  localparam int NBYTES = 64;
  localparam int NUNITS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strict_en = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic req_we = 1'b0;
  logic [63:0] req_wdata = '0;
  logic rsp_done, rsp_fault;
  logic [1:0] rsp_class;
  logic [63:0] rsp_rdata;
  logic mem_valid, mem_we;
  logic mem_ready;
  logic [UW-1:0] mem_unit;
  logic [63:0] mem_wdata;
  logic mem_rvalid;
  logic [63:0] mem_rdata;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  unaligned_splitter #(.ADDR_W(AW), .UNIT_BYTES(8)) u_unaligned_splitter (
    .clk(clk), .rst(rst), .strict_en(strict_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_class(rsp_class),
    .rsp_rdata(rsp_rdata), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_unit(mem_unit), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // Memory model with transaction log
  logic [63:0] memu [NUNITS];
  logic        log_we [16];
  logic [UW-1:0] log_u [16];
  int ntx;
  logic [4:0] lfsr;

  always @(posedge clk) begin
    if (rst) begin
      for (int u = 0; u < NUNITS; u++)
        for (int b = 0; b < 8; b++)
          memu[u][b*8 +: 8] <= init_byte(u*8 + b);
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      mem_ready  <= 1'b1;
      lfsr       <= 5'h13;
      ntx        <= 0;
    end else begin
      lfsr       <= {lfsr[3:0], lfsr[4] ^ lfsr[2]};
      mem_ready  <= lfsr[0] | lfsr[3];
      mem_rvalid <= 1'b0;
      if (mem_valid && mem_ready) begin
        log_we[ntx % 16] <= mem_we;
        log_u[ntx % 16]  <= mem_unit;
        ntx <= ntx + 1;
        if (mem_we) memu[mem_unit] <= mem_wdata;
        else begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= memu[mem_unit];
        end
      end
    end
  end

  function automatic logic [7:0] init_byte(input int i);
    return 8'(i * 59 + 17);
  endfunction

  logic [7:0] gold [NBYTES];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_access(input int a, input int sz, input bit we, input bit strict);
    int n, off, un, base, waited, exp_cnt, mism;
    bit split, mis, exp_fault, got, ready_bad, seq_ok;
    logic [63:0] wd, exp_data;
    logic [1:0] exp_cls;
    bit ew [4];
    int eu [4];
    n = 1 << sz;
    off = a % 8;
    un = a / 8;
    split = (off + n) > 8;
    mis = (a % n) != 0;
    exp_fault = strict && mis;
    exp_cls = !mis ? 2'd0 : (split ? 2'd2 : 2'd1);
    wd = 64'h0123_4567_89AB_CDEF ^ (64'(a) * 64'h9E37_79B9_7F4A_7C15) ^ 64'(sz << 5);
    exp_data = '0;
    if (!we && !exp_fault)
      for (int k = 0; k < n; k++) exp_data[k*8 +: 8] = gold[(a + k) % NBYTES];
    exp_cnt = 0;
    if (!exp_fault) begin
      ew[exp_cnt] = 0; eu[exp_cnt] = un; exp_cnt++;
      if (split) begin ew[exp_cnt] = 0; eu[exp_cnt] = (un + 1) % NUNITS; exp_cnt++; end
      if (we) begin
        ew[exp_cnt] = 1; eu[exp_cnt] = un; exp_cnt++;
        if (split) begin ew[exp_cnt] = 1; eu[exp_cnt] = (un + 1) % NUNITS; exp_cnt++; end
        for (int k = 0; k < n; k++) gold[(a + k) % NBYTES] = wd[k*8 +: 8];
      end
    end

    @(negedge clk);
    base = ntx;
    req_addr = AW'(a); req_size = 2'(sz); req_we = we; req_wdata = wd;
    strict_en = strict; req_valid = 1'b1;
    waited = 0; got = 0; ready_bad = 0;
    while (!got && waited < 200) begin
      @(negedge clk);
      req_valid = 1'b0;
      waited++;
      if (rsp_done) got = 1;
      else if (req_ready) ready_bad = 1;
    end
    check(got, "R8 completion (watchdog)", 64'(waited), 64'd0);
    check(rsp_fault == exp_fault, "R7 fault flag", 64'(rsp_fault), 64'(exp_fault));
    check(rsp_class == exp_cls, "R6 class", 64'(rsp_class), 64'(exp_cls));
    if (exp_fault) begin
      check(waited == 1, "R7 one-cycle fault", 64'(waited), 64'd1);
      check(ntx == base, "R7 no memory traffic", 64'(ntx - base), 64'd0);
    end else begin
      check(!ready_bad, "R8 ready low while busy", 64'(ready_bad), 64'd0);
      seq_ok = (ntx - base) == exp_cnt;
      if (seq_ok)
        for (int k = 0; k < exp_cnt; k++)
          if (log_we[(base + k) % 16] != ew[k] || int'(log_u[(base + k) % 16]) != eu[k]) seq_ok = 0;
      check(seq_ok, we ? "R1 R4 R5 transaction order" : "R1 R2 R3 transaction order",
            64'(ntx - base), 64'(exp_cnt));
    end
    check(rsp_rdata == exp_data, split ? "R3 load data" : "R2 R6 load data", rsp_rdata, exp_data);
    if (we) begin
      mism = -1;
      for (int i = NBYTES - 1; i >= 0; i--)
        if (memu[i / 8][(i % 8)*8 +: 8] != gold[i]) mism = i;
      check(mism < 0, exp_fault ? "R7 memory untouched" : (split ? "R5 memory image" : "R4 memory image"),
            mism < 0 ? 64'd0 : 64'(memu[mism / 8][(mism % 8)*8 +: 8]),
            mism < 0 ? 64'd0 : 64'(gold[mism]));
    end
  endtask

  initial begin
    for (int i = 0; i < NBYTES; i++) gold[i] = init_byte(i);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready after reset", 64'(req_ready), 64'd1);
    check(rsp_done == 1'b0, "R9 done low after reset", 64'(rsp_done), 64'd0);
    check(mem_valid == 1'b0, "R9 memory idle after reset", 64'(mem_valid), 64'd0);
    for (int st = 0; st < 2; st++)
      for (int w = 0; w < 2; w++)
        for (int sz = 0; sz < 4; sz++)
          for (int a = 0; a < NBYTES; a++)
            run_access(a, sz, w[0], st[0]);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule